// File: doc/BRIEF.md
# Serial-Controlled Converter Digital Interface

This block is the digital front end of a successive-approximation converter that a host drives over a four-wire serial link. The host controls the link with an active-low select, a host-driven shift clock, a serial control input and a serial result output. An end-of-conversion flag shows the host when a result is ready. In each I/O frame the host shifts in an 8-bit control word. At the same time the block shifts out the result of the conversion that came before. All port sampling uses the block's own system clock. The select and shift-clock inputs pass through a short synchronizer, and their edges are detected before use.

The control word carries a 4-bit channel address in bits [7:4] and a frame-length code in bits [3:2]. Bits [1:0] are unused. The word arrives MSB first. When the last falling shift-clock edge of the frame has been seen, the word is latched and a conversion starts. During the conversion the sequencer steps one result bit per internal tick. It drives a trial code to an external comparator and takes each decision from a comparator input. The channel address is presented to the analog multiplexer. The result register is loaded when the last bit is decided, and that result is returned in the next frame.

Top module: `adcs_top`

## Requirements
- R1: After reset, `eoc` is 1, the latched control word is all zeros (so `mux_sel` is 0), and the block waits for a falling edge of `cs_n` before a frame starts.
- R2: The control word is taken MSB first on rising `io_clk` edges. After the frame ends, `mux_sel` shows control bits [7:4].
- R3: Only the first 8 rising `io_clk` edges of a frame sample `sdi`. Bits that arrive later in a 12- or 16-clock frame do not change the latched control word.
- R4: Control bits [3:2] set the frame length: 2'b01 gives 8 clocks, 2'b11 gives 16 clocks, and 2'b00 or 2'b10 gives 12 clocks. `eoc` stays high through the falling edge before the last one and goes low only after the last falling edge.
- R5: When `cs_n` falls while no frame or conversion is in progress, the MSB of the stored result appears on `sdo` before the first rising `io_clk` edge.
- R6: When a conversion completes while `cs_n` is low, a new frame starts at once, and the new result's MSB is on `sdo` in the cycle that `eoc` rises.
- R7: Each later result bit moves onto `sdo` at a falling `io_clk` edge. An 8-clock frame returns result bits [11:4]. A 12-clock frame returns all 12 bits. A 16-clock frame returns all 12 bits followed by four zeros.
- R8: Frame N returns the result of conversion N-1, not the result of the conversion that frame N starts.
- R9: The sequencer resolves 12 bits MSB first. Bit k is set to 1 exactly when `cmp_in` is 1 while `dac_code` holds the trial code with bit k set. With a comparator that answers `input >= dac_code`, the result equals the input code, including 0 and 4095.
- R10: `eoc` is low for exactly 12*TICK_DIV+1 system clock cycles per conversion. It rises in the cycle after the result register is loaded.
- R11: If `cs_n` goes high in the middle of a frame, the frame is abandoned. No conversion starts, the latched control word is unchanged, and the next falling edge of `cs_n` starts a fresh frame that returns the same stored result.
- R12: `sdo_oe` is 0 (output high-impedance) whenever `cs_n` is 1, and 1 when `cs_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the time base for the conversion tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| io_clk | input | 1 | Host shift clock |
| sdi | input | 1 | Serial control input |
| cmp_in | input | 1 | Comparator decision: 1 when the sampled input is at or above `dac_code` |
| sdo | output | 1 | Serial result output |
| sdo_oe | output | 1 | Drive enable for `sdo`; 0 means high-impedance |
| eoc | output | 1 | End-of-conversion flag, low while a conversion runs |
| dac_code | output | 12 | Trial code for the comparator's reference DAC |
| mux_sel | output | 4 | Channel address from the latched control word |

## Verification
The input codes are 0xA5C, 0x123, 0xFFF and 0x000. Each one differs from the code before it in its MSB or in its low nibble, so a result that is returned one frame late, or a nibble that is dropped, gives a wrong word. The frame tests use all three length codes. Each test checks that `eoc` is still high one falling edge before the end and low right after the end, which shows an off-by-one in the frame counter. A 16-clock frame is fed non-zero bits after bit 8. This separates a control register that keeps shifting from one that freezes after bit 8. An aborted five-clock frame, followed by a full frame, shows whether a cancelled frame still starts a conversion or changes the stored result.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

   typedef enum logic [1:0] {
      ST_ARMED = 2'd0,
      ST_FRAME = 2'd1,
      ST_CONV  = 2'd2
   } adcs_state_e;

   // position of the two-bit length code inside the control word
   localparam int LEN_LSB  = 2;
   // position of the channel address inside the control word
   localparam int ADDR_LSB = 4;
   localparam int ADDR_W   = 4;

   // number of shift clocks in a frame for a given length code
   function automatic int frame_len(input logic [1:0] code);
      case (code)
         2'b01:   return 8;
         2'b11:   return 16;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/adcs_edge.sv
module adcs_edge #(
   parameter int   SYNC_STAGES = 2,
   parameter logic RST_VAL     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);

   logic prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {SYNC_STAGES{RST_VAL}};
            else if (SYNC_STAGES == 1) chain <= din;
            else chain <= {chain[SYNC_STAGES-2:0], din};
         end
         assign level = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= level;
   end

   assign rise = level & ~prev;
   assign fall = ~level & prev;

endmodule

// File: rtl/adcs_shift.sv
module adcs_shift
   import adcs_pkg::*;
#(
   parameter int CTRL_W    = 8,
   parameter int RES_W     = 12,
   parameter int FRAME_MAX = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              active,
   input  logic              io_rise,
   input  logic              io_fall,
   input  logic              sdi,
   input  logic [RES_W-1:0]  res_in,
   output logic              sdo,
   output logic              frame_end,
   output logic [CTRL_W-1:0] ctrl_word
);

   localparam int CNT_W = $clog2(FRAME_MAX + 1);
   localparam int PAD_W = FRAME_MAX - RES_W;

   logic [CTRL_W-1:0]    ctrl_sr;
   logic [CNT_W-1:0]     rcnt;
   logic [CNT_W-1:0]     fcnt;
   logic [FRAME_MAX-1:0] out_sr;
   logic                 take_bit;

   assign take_bit  = active && io_rise && (int'(rcnt) < CTRL_W);
   assign frame_end = active && io_fall &&
                      (int'(fcnt) == frame_len(ctrl_sr[LEN_LSB +: 2]) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_sr <= '0;
         rcnt    <= '0;
         fcnt    <= '0;
         out_sr  <= '0;
      end else if (load) begin
         ctrl_sr <= '0;
         rcnt    <= '0;
         fcnt    <= '0;
         out_sr  <= {res_in, {PAD_W{1'b0}}};
      end else begin
         if (take_bit) begin
            ctrl_sr <= {ctrl_sr[CTRL_W-2:0], sdi};
            rcnt    <= rcnt + 1'b1;
         end
         if (active && io_fall) begin
            out_sr <= {out_sr[FRAME_MAX-2:0], 1'b0};
            fcnt   <= fcnt + 1'b1;
         end
      end
   end

   assign sdo       = out_sr[FRAME_MAX-1];
   assign ctrl_word = ctrl_sr;

   // R3
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && active && io_rise && int'(rcnt) == CTRL_W) |=> $stable(ctrl_sr));

   // R7
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !(active && io_fall)) |=> $stable(sdo));

endmodule

// File: rtl/adcs_sar.sv
module adcs_sar #(
   parameter int RES_W    = 12,
   parameter int TICK_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmp_in,
   output logic [RES_W-1:0] trial,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] result
);

   localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
   localparam int TCK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic [IDX_W-1:0] idx;
   logic [TCK_W-1:0] tcnt;
   logic             tick;
   logic [RES_W-1:0] decided;

   assign tick = busy && (int'(tcnt) == TICK_DIV - 1);

   always_comb begin
      decided      = trial;
      decided[idx] = cmp_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial  <= '0;
         idx    <= '0;
         tcnt   <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            trial          <= '0;
            trial[RES_W-1] <= 1'b1;
            idx            <= IDX_W'(RES_W - 1);
            tcnt           <= '0;
            busy           <= 1'b1;
         end else if (tick) begin
            tcnt <= '0;
            if (idx != '0) begin
               trial            <= decided;
               trial[idx - 1'b1] <= 1'b1;
               idx              <= idx - 1'b1;
            end else begin
               trial  <= decided;
               result <= decided;
               busy   <= 1'b0;
               done   <= 1'b1;
            end
         end else if (busy) begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   // R9
   trial_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> trial[idx]);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

endmodule

// File: rtl/adcs_top.sv
module adcs_top
   import adcs_pkg::*;
#(
   parameter int CTRL_W      = 8,
   parameter int RES_W       = 12,
   parameter int FRAME_MAX   = 16,
   parameter int TICK_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             io_clk,
   input  logic             sdi,
   input  logic             cmp_in,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             eoc,
   output logic [RES_W-1:0] dac_code,
   output logic [3:0]       mux_sel
);

   generate
      if (CTRL_W != 8) begin : g_bad_ctrl
         $error("adcs_top: control word must be 8 bits");
      end
      if (RES_W > FRAME_MAX || RES_W < 8) begin : g_bad_res
         $error("adcs_top: result width must lie between 8 and FRAME_MAX");
      end
      if (TICK_DIV < 1) begin : g_bad_tick
         $error("adcs_top: TICK_DIV must be at least 1");
      end
   endgenerate

   adcs_state_e       state;
   logic              cs_lvl, cs_rise, cs_fall;
   logic              io_lvl, io_rise, io_fall;
   logic              cs_low;
   logic              load, sar_start, sar_busy, sar_done;
   logic              frame_end, active;
   logic [CTRL_W-1:0] ctrl_word, ctrl_reg;
   logic [RES_W-1:0]  result;

   adcs_edge #(.SYNC_STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cs_edge (
      .clk(clk), .rst_n(rst_n), .din(cs_n),
      .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));

   adcs_edge #(.SYNC_STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_io_edge (
      .clk(clk), .rst_n(rst_n), .din(io_clk),
      .level(io_lvl), .rise(io_rise), .fall(io_fall));

   assign cs_low    = ~cs_lvl;
   assign active    = (state == ST_FRAME);
   assign load      = (state == ST_ARMED && cs_fall) ||
                      (state == ST_CONV && sar_done && cs_low);
   assign sar_start = active && !cs_rise && frame_end;

   adcs_shift #(.CTRL_W(CTRL_W), .RES_W(RES_W), .FRAME_MAX(FRAME_MAX)) i_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .active(active),
      .io_rise(io_rise), .io_fall(io_fall), .sdi(sdi), .res_in(result),
      .sdo(sdo), .frame_end(frame_end), .ctrl_word(ctrl_word));

   adcs_sar #(.RES_W(RES_W), .TICK_DIV(TICK_DIV)) i_sar (
      .clk(clk), .rst_n(rst_n), .start(sar_start), .cmp_in(cmp_in),
      .trial(dac_code), .busy(sar_busy), .done(sar_done), .result(result));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_ARMED;
         eoc      <= 1'b1;
         ctrl_reg <= '0;
      end else begin
         case (state)
            ST_ARMED: if (cs_fall) state <= ST_FRAME;
            ST_FRAME: begin
               if (cs_rise) begin
                  state <= ST_ARMED;
               end else if (frame_end) begin
                  state    <= ST_CONV;
                  eoc      <= 1'b0;
                  ctrl_reg <= ctrl_word;
               end
            end
            ST_CONV: begin
               if (sar_done) begin
                  eoc   <= 1'b1;
                  state <= cs_low ? ST_FRAME : ST_ARMED;
               end
            end
            default: state <= ST_ARMED;
         endcase
      end
   end

   assign sdo_oe  = ~cs_n;
   assign mux_sel = ctrl_reg[ADDR_LSB +: ADDR_W];

   // R10
   eoc_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CONV) |-> !eoc);

   // R4
   conv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eoc) |-> $past(frame_end));

   // R6
   eoc_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(eoc) && $past(cs_low)) |-> (state == ST_FRAME));

   // R11
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cs_rise) |=> (state == ST_ARMED && eoc));

   // R9
   conv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CONV && !$past(sar_start)) |-> (sar_busy || sar_done));

endmodule

// File: tb/test_adcs_top.sv
module test_adcs_top;

   localparam int TICK = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        io_clk = 1'b0;
   logic        sdi = 1'b0;
   logic [11:0] vin = '0;
   logic        cmp_in;
   logic        sdo, sdo_oe, eoc;
   logic [11:0] dac_code;
   logic [3:0]  mux_sel;

   int  nrun = 0;
   int  nfail = 0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;

   assign cmp_in = (vin >= dac_code);

   adcs_top #(.TICK_DIV(TICK)) i_adcs_top (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk), .sdi(sdi),
      .cmp_in(cmp_in), .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc),
      .dac_code(dac_code), .mux_sel(mux_sel));

   task automatic chk(input bit ok, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      nrun++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drives n shift clocks; when full, checks frame-end timing (R4, R10)
   task automatic do_frame(input logic [7:0] cw, input int n, input logic garb,
                           input bit full, output logic [15:0] cap);
      cap = '0;
      for (int k = 0; k < n; k++) begin
         sdi = (k < 8) ? cw[7-k] : (garb ^ k[0]);
         wait_clk(2);
         cap[15-k] = sdo;
         io_clk = 1'b1;
         wait_clk(5);
         io_clk = 1'b0;
         if (full && k == n - 1) begin
            int w = 0;
            int cnt = 0;
            while (eoc && w < 10) begin
               @(negedge clk);
               w++;
            end
            chk(!eoc, "R4 eoc low after last fall", {15'd0, eoc}, 16'd0);
            while (!eoc && cnt < 1000) begin
               @(negedge clk);
               cnt++;
            end
            chk(cnt == 12 * TICK + 1, "R10 conversion length",
                16'(cnt), 16'(12 * TICK + 1));
         end else begin
            wait_clk(5);
            if (full && k == n - 2)
               chk(eoc, "R4 eoc high before last fall", {15'd0, eoc}, 16'd1);
         end
      end
      sdi = 1'b0;
   endtask

   task automatic t_reset;
      chk(eoc == 1'b1, "R1 eoc after reset", {15'd0, eoc}, 16'd1);
      chk(mux_sel == 4'h0, "R1 control cleared", {12'd0, mux_sel}, 16'd0);
      chk(sdo_oe == 1'b0, "R12 oe with cs high", {15'd0, sdo_oe}, 16'd0);
   endtask

   task automatic t_first;
      logic [15:0] cap;
      vin  = 12'hA5C;
      cs_n = 1'b0;
      wait_clk(4);
      chk(sdo_oe == 1'b1, "R12 oe with cs low", {15'd0, sdo_oe}, 16'd1);
      do_frame({4'h3, 2'b00, 2'b00}, 12, 1'b0, 1'b1, cap);
      chk(mux_sel == 4'h3, "R2 address latched", {12'd0, mux_sel}, 16'h3);
      chk(sdo == 1'b1, "R6 msb at eoc rise", {15'd0, sdo}, 16'd1);
   endtask

   task automatic t_len16;
      logic [15:0] cap;
      vin = 12'h123;
      do_frame({4'h5, 2'b11, 2'b00}, 16, 1'b1, 1'b1, cap);
      chk(cap == 16'hA5C0, "R7 R8 R9 16-clock readout", cap, 16'hA5C0);
      chk(mux_sel == 4'h5, "R3 late sdi ignored", {12'd0, mux_sel}, 16'h5);
      chk(sdo == 1'b0, "R6 msb at eoc rise", {15'd0, sdo}, 16'd0);
   endtask

   task automatic t_len8;
      logic [15:0] cap;
      vin = 12'hFFF;
      do_frame({4'hA, 2'b01, 2'b00}, 8, 1'b0, 1'b1, cap);
      chk(cap[15:8] == 8'h12, "R7 8-clock readout", {8'd0, cap[15:8]}, 16'h12);
      chk(mux_sel == 4'hA, "R2 address latched", {12'd0, mux_sel}, 16'hA);
   endtask

   task automatic t_csfall;
      logic [15:0] cap;
      cs_n = 1'b1;
      wait_clk(4);
      chk(sdo_oe == 1'b0, "R12 oe with cs high", {15'd0, sdo_oe}, 16'd0);
      vin  = 12'h000;
      cs_n = 1'b0;
      wait_clk(4);
      chk(sdo == 1'b1, "R5 msb at cs fall", {15'd0, sdo}, 16'd1);
      do_frame({4'h6, 2'b10, 2'b00}, 12, 1'b0, 1'b1, cap);
      chk(cap[15:4] == 12'hFFF, "R5 R8 12-clock readout", {4'd0, cap[15:4]},
          16'h0FFF);
   endtask

   task automatic t_abort;
      logic [15:0] cap;
      cs_n = 1'b1;
      wait_clk(4);
      cs_n = 1'b0;
      wait_clk(4);
      do_frame({4'hC, 2'b00, 2'b00}, 5, 1'b0, 1'b0, cap);
      cs_n = 1'b1;
      wait_clk(20);
      chk(eoc == 1'b1, "R11 no conversion after abort", {15'd0, eoc}, 16'd1);
      chk(mux_sel == 4'h6, "R11 control kept", {12'd0, mux_sel}, 16'h6);
      cs_n = 1'b0;
      wait_clk(4);
      do_frame({4'h9, 2'b00, 2'b00}, 12, 1'b0, 1'b1, cap);
      chk(cap[15:4] == 12'h000, "R11 R9 restart readout", {4'd0, cap[15:4]},
          16'h0000);
      chk(mux_sel == 4'h9, "R11 restarted frame", {12'd0, mux_sel}, 16'h9);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      t_reset();
      t_first();
      t_len16();
      t_len8();
      t_csfall();
      t_abort();
      wait_clk(5);
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", nrun, nfail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nrun++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", nrun, nfail);
         $finish;
      end
   end

endmodule